// File: doc/BRIEF.md
# Four-Port Input-Queued Packet Crossbar

This block switches packets between four input streams and four output streams. Each input buffers arriving flits in its own queue. A small route controller reads the destination field of the packet at the head of that queue and raises a request to one output. Each output has its own arbiter. The arbiter picks one requesting input and keeps the crossbar path from that input to the output until the packet's last flit has left. Flits move through as soon as the path exists, so a packet can start leaving before it has fully arrived.

The arbitration rule is chosen at run time from three policies:
- **Fixed priority.** The lowest input index wins.
- **Oldest request.** The input that has waited longest wins. Waiting time is tracked per input by a saturating counter, and equal ages go to the lower index.
- **Rotating search.** The search starts from a point taken from a free-running 16-bit LFSR in each arbiter.

Only head packets can request an output. A packet that is stuck behind a blocked head therefore waits, even when the output it needs is free.

Streams use valid/ready handshakes with start and end markers on every flit. All outputs come from registers.

Top module: `xbar_switch`

## Requirements
- R1: After reset every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A packet whose head flit carries destination d in data bits [1:0] leaves on output d. All its flits come out in order, with start and end markers unchanged.
- R3: Once an output has started a packet, no flit from any other input appears on it until that packet's end flit has passed.
- R4: Packets from one input to one output leave in the order they entered.
- R5: With `arb_mode` = 0 (fixed priority), inputs that contend for an output at the same moment are served in ascending index order.
- R6: With `arb_mode` = 1 (oldest request), a freed output goes to the input that has been requesting it longest, even when a lower-index input is also waiting.
- R7: With `arb_mode` = 2 (rotating search), every contending input is eventually served, and packets are not interleaved on the output.
- R8: A head packet waiting for a busy output holds back the packets behind it in its queue, even when their destination output is idle. The head is not bypassed.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output holds `out_valid` and keeps its data stable.
- R10: An input holds at most DEPTH flits. When its queue is full, `in_ready` drops to 0 and no flit is lost.
- R11: Take a head flit accepted into an empty queue whose target output is idle and ready. That flit is on `out_valid` after the third clock edge that follows the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_mode | input | 2 | Arbitration policy: 0 fixed, 1 oldest request, 2 rotating search, 3 same as 0 |
| in_valid | input | NP | Flit valid, one bit per input |
| in_ready | output | NP | Queue can accept a flit |
| in_data | input | NP*DW | Flit payload per input; head flit bits [IW-1:0] hold the destination |
| in_sop | input | NP | Flit starts a packet |
| in_eop | input | NP | Flit ends a packet |
| out_valid | output | NP | Output flit valid |
| out_ready | input | NP | Downstream accepts flit |
| out_data | output | NP*DW | Output payload per port |
| out_sop | output | NP | Output flit starts a packet |
| out_eop | output | NP | Output flit ends a packet |

## Verification
The first pattern is a permutation, where every input targets a different output. It separates plain routing and its latency from any arbitration effect. The bench then makes all four inputs hit one output at once in each policy, which tells the three policies apart:
- Fixed priority serves the inputs in strict index order.
- Oldest request serves a late high-index requester before a later low-index one.
- Rotating search must still deliver every packet whole, with per-input order kept.

A held-back output exposes head-of-line blocking, because a free output receives nothing from the blocked queue while another input still gets through. A stalled output with a long packet fills a queue, which exposes the full limit and the output hold behaviour.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic [1:0] {
    ARB_FIXED  = 2'd0,
    ARB_OLDEST = 2'd1,
    ARB_ROTATE = 2'd2
  } arb_mode_e;

  typedef enum logic [1:0] {
    RT_IDLE = 2'd0,
    RT_REQ  = 2'd1,
    RT_XFER = 2'd2
  } route_state_e;

  function automatic logic [15:0] lfsr16_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/xbar_fifo.sv
module xbar_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (wr_en && !rd_en)      cnt <= cnt + 1'b1;
      else if (!wr_en && rd_en) cnt <= cnt - 1'b1;
    end
  end

  assign rd_data = mem[rp];
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R2
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          head_valid,
  input  logic [IW-1:0] head_dest,
  input  logic          grant,
  input  logic          eop_popped,
  output logic [N-1:0]  req,
  output logic [IW-1:0] dest
);
  route_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RT_IDLE;
      dest  <= '0;
    end else begin
      unique case (state)
        RT_IDLE: if (head_valid) begin
          dest  <= head_dest;
          state <= RT_REQ;
        end
        RT_REQ: if (grant) state <= eop_popped ? RT_IDLE : RT_XFER;
        RT_XFER: if (eop_popped) state <= RT_IDLE;
        default: state <= RT_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int o = 0; o < N; o++) req[o] = (state == RT_REQ) && (dest == IW'(o));
  end

  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req));

  // R3
  xfer_until_eop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RT_XFER) && !eop_popped |=> (state == RT_XFER) && $stable(dest));

endmodule

// File: rtl/xbar_out_arb.sv
module xbar_out_arb
  import xbar_pkg::*;
#(
  parameter int          N     = 4,
  parameter int          IW    = 2,
  parameter int          AGE_W = 4,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic [N-1:0]  req,
  input  logic          release_i,
  output logic          locked,
  output logic [IW-1:0] owner
);
  logic [AGE_W-1:0] age [N];
  logic [15:0]      lfsr;
  logic [IW-1:0]    pick_fix, pick_old, pick_rot, pick;
  logic             grab;

  always_comb begin
    logic f_fix, f_old, f_rot;
    logic [AGE_W-1:0] best;
    int idx;
    pick_fix = '0; pick_old = '0; pick_rot = '0;
    f_fix = 1'b0; f_old = 1'b0; f_rot = 1'b0;
    best = '0; idx = 0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !f_fix) begin
        pick_fix = IW'(i);
        f_fix    = 1'b1;
      end
      if (req[i] && (!f_old || age[i] > best)) begin
        pick_old = IW'(i);
        best     = age[i];
        f_old    = 1'b1;
      end
    end
    for (int k = 0; k < N; k++) begin
      idx = (int'(lfsr[IW-1:0]) + k) % N;
      if (req[idx] && !f_rot) begin
        pick_rot = IW'(idx);
        f_rot    = 1'b1;
      end
    end
    unique case (mode)
      ARB_OLDEST: pick = pick_old;
      ARB_ROTATE: pick = pick_rot;
      default:    pick = pick_fix;
    endcase
  end

  assign grab = !locked && (|req);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      owner  <= '0;
      lfsr   <= SEED;
    end else begin
      lfsr <= lfsr16_next(lfsr);
      if (locked && release_i) begin
        locked <= 1'b0;
      end else if (grab) begin
        locked <= 1'b1;
        owner  <= pick;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst || !req[i] || (grab && pick == IW'(i))) age[i] <= '0;
      else if (age[i] != '1) age[i] <= age[i] + 1'b1;
    end
  end

  // R3
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked && !release_i |=> locked && $stable(owner));

  // R7
  grant_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    !locked && (|req) |=> locked);

endmodule

// File: rtl/xbar_crossbar.sv
module xbar_crossbar #(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  locked,
  input  logic [IW-1:0] owner     [N],
  input  logic [N-1:0]  q_valid,
  input  logic [DW-1:0] q_data    [N],
  input  logic [N-1:0]  q_sop,
  input  logic [N-1:0]  q_eop,
  input  logic [N-1:0]  out_ready,
  output logic [N-1:0]  pop,
  output logic [N-1:0]  release_o,
  output logic [N-1:0]  ov,
  output logic [DW-1:0] od        [N],
  output logic [N-1:0]  osop,
  output logic [N-1:0]  oeop
);
  logic [N-1:0] move;

  always_comb begin
    pop       = '0;
    move      = '0;
    release_o = '0;
    for (int o = 0; o < N; o++) begin
      move[o]      = locked[o] && q_valid[owner[o]] && (!ov[o] || out_ready[o]);
      release_o[o] = move[o] && q_eop[owner[o]];
      if (move[o]) pop[owner[o]] = 1'b1;
    end
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        ov[o]   <= 1'b0;
        osop[o] <= 1'b0;
        oeop[o] <= 1'b0;
      end else if (move[o]) begin
        ov[o]   <= 1'b1;
        osop[o] <= q_sop[owner[o]];
        oeop[o] <= q_eop[owner[o]];
      end else if (out_ready[o]) begin
        ov[o] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (move[o]) od[o] <= q_data[owner[o]];
    end

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ov[o] && !out_ready[o] |=> ov[o] && $stable(od[o]));
  end

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int NP    = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AGE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       arb_mode,
  input  logic [NP-1:0]    in_valid,
  output logic [NP-1:0]    in_ready,
  input  logic [NP*DW-1:0] in_data,
  input  logic [NP-1:0]    in_sop,
  input  logic [NP-1:0]    in_eop,
  output logic [NP-1:0]    out_valid,
  input  logic [NP-1:0]    out_ready,
  output logic [NP*DW-1:0] out_data,
  output logic [NP-1:0]    out_sop,
  output logic [NP-1:0]    out_eop
);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;
  localparam int FW = DW + 2;

  logic [NP-1:0] q_valid, q_sop, q_eop, q_full, q_empty, pop, gnt_in;
  logic [DW-1:0] q_data  [NP];
  logic [NP-1:0] req_in  [NP];
  logic [NP-1:0] req_out [NP];
  logic [IW-1:0] r_dest  [NP];
  logic [IW-1:0] owner   [NP];
  logic [NP-1:0] locked, release_o;
  logic [DW-1:0] od      [NP];

  for (genvar i = 0; i < NP; i++) begin : g_in
    logic [FW-1:0] rd_word;

    xbar_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (in_valid[i] && !q_full[i]),
      .wr_data ({in_sop[i], in_eop[i], in_data[i*DW +: DW]}),
      .full    (q_full[i]),
      .rd_en   (pop[i]),
      .rd_data (rd_word),
      .empty   (q_empty[i])
    );

    assign {q_sop[i], q_eop[i], q_data[i]} = rd_word;
    assign q_valid[i]  = !q_empty[i];
    assign in_ready[i] = !q_full[i];
    assign gnt_in[i]   = locked[r_dest[i]] && (owner[r_dest[i]] == IW'(i));

    xbar_route #(.N(NP), .IW(IW)) u_route (
      .clk        (clk),
      .rst        (rst),
      .head_valid (q_valid[i]),
      .head_dest  (q_data[i][IW-1:0]),
      .grant      (gnt_in[i]),
      .eop_popped (pop[i] && q_eop[i]),
      .req        (req_in[i]),
      .dest       (r_dest[i])
    );
  end

  for (genvar o = 0; o < NP; o++) begin : g_arb
    for (genvar i = 0; i < NP; i++) begin : g_map
      assign req_out[o][i] = req_in[i][o];
    end

    xbar_out_arb #(
      .N(NP), .IW(IW), .AGE_W(AGE_W),
      .SEED(16'hACE1 ^ 16'(o * 16'h1357))
    ) u_arb (
      .clk       (clk),
      .rst       (rst),
      .mode      (arb_mode),
      .req       (req_out[o]),
      .release_i (release_o[o]),
      .locked    (locked[o]),
      .owner     (owner[o])
    );

    assign out_data[o*DW +: DW] = od[o];

    // R2
    dest_match_chk: assert property (@(posedge clk) disable iff (rst)
      locked[o] |-> r_dest[owner[o]] == IW'(o));
  end

  xbar_crossbar #(.N(NP), .DW(DW), .IW(IW)) u_xbar (
    .clk       (clk),
    .rst       (rst),
    .locked    (locked),
    .owner     (owner),
    .q_valid   (q_valid),
    .q_data    (q_data),
    .q_sop     (q_sop),
    .q_eop     (q_eop),
    .out_ready (out_ready),
    .pop       (pop),
    .release_o (release_o),
    .ov        (out_valid),
    .od        (od),
    .osop      (out_sop),
    .oeop      (out_eop)
  );

endmodule

// File: tb/xbar_switch_tb.sv
`timescale 1ns/1ps
module xbar_switch_tb;
  localparam int NP = 4;
  localparam int DW = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] arb_mode = 2'd0;
  logic [NP-1:0] in_valid, in_ready, in_sop, in_eop;
  logic [NP*DW-1:0] in_data;
  logic [NP-1:0] out_valid, out_ready, out_sop, out_eop;
  logic [NP*DW-1:0] out_data;

  always #4 clk = ~clk;

  xbar_switch #(.NP(NP), .DW(DW), .DEPTH(DEPTH), .AGE_W(4)) u_dut (
    .clk(clk), .rst(rst), .arb_mode(arb_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  logic [17:0] stage [NP][$];
  logic [17:0] olog  [NP][$];
  logic [17:0] expq  [NP][$];
  int acc_cnt [NP];
  int rd_idx  [NP];
  int checks = 0, failures = 0;
  int mon_checks = 0, mon_fail = 0;

  // input drivers: present head of each staging queue, pop on handshake
  initial begin
    bit acc [NP];
    in_valid = '0; in_sop = '0; in_eop = '0; in_data = '0;
    for (int g = 0; g < NP; g++) acc_cnt[g] = 0;
    forever begin
      @(negedge clk);
      for (int g = 0; g < NP; g++) acc[g] = in_valid[g] && in_ready[g];
      @(posedge clk); #1;
      for (int g = 0; g < NP; g++) begin
        if (acc[g]) begin
          void'(stage[g].pop_front());
          acc_cnt[g]++;
        end
        if (stage[g].size() > 0) begin
          in_valid[g] = 1'b1;
          {in_sop[g], in_eop[g], in_data[g*DW +: DW]} = stage[g][0];
        end else begin
          in_valid[g] = 1'b0;
        end
      end
    end
  end

  // output monitor, also checks R9 hold behaviour
  initial begin
    bit stall [NP];
    logic [15:0] pd [NP];
    for (int o = 0; o < NP; o++) stall[o] = 1'b0;
    forever begin
      @(negedge clk);
      for (int o = 0; o < NP; o++) begin
        if (stall[o]) begin
          mon_checks++;
          if (!(out_valid[o] && out_data[o*DW +: DW] == pd[o])) begin
            mon_fail++;
            $display("FAIL R9 out%0d hold: actual valid=%0b data=%h expected valid=1 data=%h",
                     o, out_valid[o], out_data[o*DW +: DW], pd[o]);
          end
        end
        if (out_valid[o] && out_ready[o])
          olog[o].push_back({out_sop[o], out_eop[o], out_data[o*DW +: DW]});
        stall[o] = out_valid[o] && !out_ready[o];
        pd[o]    = out_data[o*DW +: DW];
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, failures + mon_fail + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // flit: [15:14]=src [13:8]=seq [7:4]=index [1:0]=dest
  task automatic mk_pkt(input int src, input int dst, input int len, input int seq);
    for (int k = 0; k < len; k++) begin
      logic [17:0] f;
      f = {(k == 0), (k == len - 1), 2'(src), 6'(seq), 4'(k), 2'b00, 2'(dst)};
      stage[src].push_back(f);
      expq[dst].push_back(f);
    end
  endtask

  task automatic drain();
    repeat (80) @(negedge clk);
  endtask

  task automatic compare_out(input string tag);
    for (int o = 0; o < NP; o++) begin
      int n, bad;
      n = olog[o].size() - rd_idx[o];
      bad = -1;
      if (n == expq[o].size())
        for (int k = 0; k < n; k++)
          if (bad < 0 && olog[o][rd_idx[o] + k] != expq[o][k]) bad = k;
      if (n != expq[o].size())
        chk(1'b0, tag, n, expq[o].size());
      else if (bad >= 0)
        chk(1'b0, tag, int'(olog[o][rd_idx[o] + bad]), int'(expq[o][bad]));
      else
        chk(1'b1, tag, n, n);
      rd_idx[o] = olog[o].size();
      expq[o].delete();
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '1, "R1 in_ready after reset", int'(in_ready), 15);
  endtask

  task automatic t_permute();
    int n;
    arb_mode = 2'd0;
    for (int i = 0; i < NP; i++) mk_pkt(i, (i + 1) % NP, 3, 1);
    for (int i = 0; i < NP; i++) mk_pkt(i, (i + 1) % NP, 2, 2);
    do @(negedge clk); while (!in_valid[0]);
    n = 0;
    do begin @(negedge clk); n++; end while (!out_valid[1] && n < 20);
    chk(n == 4, "R11 head latency in edges", n, 4);
    drain();
    compare_out("R2/R4 permutation routing and order");
  endtask

  task automatic t_fixed();
    arb_mode = 2'd0;
    for (int i = 0; i < NP; i++) mk_pkt(i, 2, 3, 3);
    drain();
    compare_out("R5/R3 fixed priority order");
  endtask

  task automatic t_oldest();
    arb_mode = 2'd1;
    mk_pkt(2, 1, 8, 4);
    repeat (3) @(negedge clk);
    mk_pkt(3, 1, 2, 4);
    repeat (2) @(negedge clk);
    mk_pkt(0, 1, 2, 4);
    drain();
    compare_out("R6 oldest request first");
  endtask

  task automatic t_rotate();
    logic [17:0] e [$];
    int n, bad, cur;
    arb_mode = 2'd2;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < NP; i++) mk_pkt(i, 0, 2 + i, 5 + p);
    e = expq[0];
    drain();
    n = olog[0].size() - rd_idx[0];
    chk(n == e.size(), "R7 rotating all flits delivered", n, e.size());
    bad = 0; cur = 0;
    for (int k = rd_idx[0]; k < olog[0].size(); k++) begin
      if (olog[0][k][17]) cur = int'(olog[0][k][15:14]);
      else if (int'(olog[0][k][15:14]) != cur) bad++;
    end
    chk(bad == 0, "R7 no interleaving under rotation", bad, 0);
    for (int s = 0; s < NP; s++) begin
      logic [17:0] a [$];
      logic [17:0] x [$];
      bit same;
      for (int k = rd_idx[0]; k < olog[0].size(); k++)
        if (int'(olog[0][k][15:14]) == s) a.push_back(olog[0][k]);
      foreach (e[k]) if (int'(e[k][15:14]) == s) x.push_back(e[k]);
      same = (a.size() == x.size());
      if (same) foreach (a[k]) if (a[k] != x[k]) same = 1'b0;
      chk(same, "R4 per-input order under rotation", a.size(), x.size());
    end
    rd_idx[0] = olog[0].size();
    expq[0].delete();
  endtask

  task automatic t_hol();
    arb_mode = 2'd0;
    out_ready[3] = 1'b0;
    mk_pkt(0, 3, 6, 7);
    repeat (2) @(negedge clk);
    mk_pkt(1, 3, 2, 7);
    mk_pkt(2, 2, 3, 7);
    mk_pkt(1, 2, 2, 8);
    repeat (25) @(negedge clk);
    chk(olog[2].size() - rd_idx[2] == 3, "R8 free output gets only the unblocked packet",
        olog[2].size() - rd_idx[2], 3);
    chk(out_valid[3] == 1'b1, "R9 stalled output keeps valid", int'(out_valid[3]), 1);
    @(posedge clk); #1;
    out_ready[3] = 1'b1;
    drain();
    compare_out("R8 head-of-line order after release");
  endtask

  task automatic t_full();
    int base;
    arb_mode = 2'd0;
    out_ready[0] = 1'b0;
    base = acc_cnt[1];
    mk_pkt(1, 0, 12, 9);
    repeat (30) @(negedge clk);
    chk(in_ready[1] == 1'b0, "R10 in_ready low when full", int'(in_ready[1]), 0);
    chk(acc_cnt[1] - base == DEPTH + 1, "R10 flits accepted while stalled",
        acc_cnt[1] - base, DEPTH + 1);
    @(posedge clk); #1;
    out_ready[0] = 1'b1;
    drain();
    compare_out("R10 no flit lost after full");
  endtask

  initial begin
    for (int o = 0; o < NP; o++) rd_idx[o] = 0;
    out_ready = '1;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_permute();
    t_fixed();
    t_oldest();
    t_rotate();
    t_hol();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
    $finish;
  end

endmodule